// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block takes received Ethernet frames as a byte stream and stores them in memory buffers. Each buffer is described by a four-word descriptor, and the descriptors are linked into a circular ring by their next-pointer words. For every descriptor, the engine first reads all four words. It then checks that the descriptor belongs to the DMA and packs the incoming bytes little-endian into whole words, writing them into the buffer. When the buffer is closed, the engine writes back the byte count and then the status word, which returns ownership to software. Finally it follows the next pointer. A frame longer than one buffer continues into the following descriptors.

Software sets the engine up through a small register write port. It can program the first and current descriptor pointers, a configuration word (stuffing pad and maximum frame length) and a command word (receive enable and a self-clearing abort). The memory port is word wide. A read returns its data on the second clock edge after the request is registered, and a write takes effect at the edge after it is presented. Two interrupt pulses report a completed frame and a frame dropped because no descriptor was available.

Top module: `rx_ring_dma`

## Requirements
- R1: A descriptor at address A has four words. A+0 is command/status: bit 31 is owned by DMA, bit 23 is the interrupt request, bit 17 is first, bit 16 is last and bit 15 is error summary. A+4 holds the byte count in bits 15:0 and the buffer size in bits 31:16. A+8 is the buffer pointer and A+12 is the next-descriptor pointer. After each descriptor is closed, the current pointer becomes that descriptor's next pointer, so the ring wraps.
- R2: When configuration bit 2 is set, two zero bytes are stored ahead of the frame in the first descriptor, and the reported byte count includes them. Byte k of a buffer goes into the word at buffer+4*(k/4), in bits 8*(k%4)+7 down to 8*(k%4).
- R3: Memory writes for a descriptor occur in this order: the data words in address order, then the count word, then the status word. The status word has bit 31 clear, keeps the descriptor's bit 23, and has all other bits zero except bits 17, 16 and 15.
- R4: A frame longer than one buffer continues into the following descriptors. Only the first of these carries bit 17. Only the final one carries bit 16, and the error summary can appear only on the final one.
- R5: Command bit 7 enables reception. While it is clear and the engine is idle, rx_ready stays low and no memory access is made.
- R6: Writing command bit 15 sets abort_busy. The engine returns to idle, after which abort_busy clears by itself and the current pointer is reloaded from the first pointer.
- R7: Configuration bits 1:0 select the maximum frame length: 0 for 1518, 1 for 1536, 2 for 2048 and 3 for 65536 bytes, with pad bytes not counted. A longer frame sets the error summary; a frame of exactly the limit does not.
- R8: rx_err asserted together with the frame's last byte sets the error summary.
- R9: If the descriptor at the start of a frame is not owned by the DMA, the frame is consumed and discarded with no memory write. irq_nodesc pulses for one cycle, and the current pointer is unchanged.
- R10: irq_done pulses in the same cycle as the status write of a frame's final descriptor, and only if that descriptor's bit 23 is set.
- R11: Buffer sizes are multiples of 4 and at least 4. The bytes of a partially filled last word that hold no data are written as zero.
- R12: Register selects are: 0 for command, 1 for configuration, 2 for the first pointer (which also loads the current pointer) and 3 for the current pointer alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| rx_valid | input | 1 | Frame byte valid |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Byte is the last of its frame |
| rx_err | input | 1 | Frame error, sampled with the last byte |
| rx_ready | output | 1 | Engine accepts a byte this cycle |
| mem_rd | output | 1 | Memory word read request |
| mem_wr | output | 1 | Memory word write request |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| irq_done | output | 1 | Frame-complete interrupt pulse |
| irq_nodesc | output | 1 | No-descriptor interrupt pulse |
| rx_on | output | 1 | Receive enable state |
| abort_busy | output | 1 | Abort in progress |
| cur_desc | output | AW | Current descriptor pointer |

## Verification
Descriptor reads take six cycles from the start of a frame to the first byte accepted. A data word is written in the cycle after the byte that completes it. The count word follows one cycle after the final data write, and the status word, together with irq_done, one cycle after that. The bench does not predict absolute cycles for these. Its reference model builds the expected ordered write stream, and every clock's write is compared against the head of that stream, which fixes both order and content. Abort takes one cycle to reach idle and one more to clear, and the register-side results (abort_busy, cur_desc) are sampled on the falling edge after the edge that updates them.

// File: rtl/rx_ring_dma.sv
module rx_ring_dma #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  input  logic          rx_err,
  output logic          rx_ready,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          irq_done,
  output logic          irq_nodesc,
  output logic          rx_on,
  output logic          abort_busy,
  output logic [AW-1:0] cur_desc
);
  localparam int CW = 16;
  localparam int FW = CW + 2;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_DATA, S_CNT, S_STAT, S_DROP} st_t;

  st_t           st;
  logic [2:0]    fc;
  logic [AW-1:0] first_ptr, dbuf, dnext;
  logic          stuff, own, irqb, firstd, lastd, errd;
  logic [1:0]    mfl;
  logic [CW-1:0] dsize, cnt;
  logic [FW-1:0] flen, limit;
  logic [31:0]   wbuf, merged;
  logic [1:0]    lane;
  logic          acc, buf_full;
  logic [CW-1:0] cnt_n;
  logic [FW-1:0] flen_n;

  always_comb begin
    case (mfl)
      2'd0:    limit = FW'(1518);
      2'd1:    limit = FW'(1536);
      2'd2:    limit = FW'(2048);
      default: limit = FW'(65536);
    endcase
  end

  assign rx_ready = (st == S_DATA) || (st == S_DROP);
  assign acc      = rx_valid && rx_ready;
  assign lane     = cnt[1:0];
  assign merged   = ((lane == 2'd0) ? 32'd0 : wbuf) | (32'(rx_data) << {lane, 3'b000});
  assign cnt_n    = cnt + 1'b1;
  assign flen_n   = flen + 1'b1;
  assign buf_full = (cnt_n == dsize);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; fc <= '0; first_ptr <= '0; cur_desc <= '0;
      dbuf <= '0; dnext <= '0; stuff <= 1'b0; own <= 1'b0; irqb <= 1'b0;
      firstd <= 1'b0; lastd <= 1'b0; errd <= 1'b0; mfl <= '0;
      dsize <= '0; cnt <= '0; flen <= '0; wbuf <= '0;
      mem_rd <= 1'b0; mem_wr <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
      irq_done <= 1'b0; irq_nodesc <= 1'b0; rx_on <= 1'b0; abort_busy <= 1'b0;
    end else begin
      mem_rd     <= 1'b0;
      mem_wr     <= 1'b0;
      irq_done   <= 1'b0;
      irq_nodesc <= 1'b0;
      if (reg_we) begin
        case (reg_sel)
          2'd0: begin
            rx_on <= reg_wdata[7];
            if (reg_wdata[15]) abort_busy <= 1'b1;
          end
          2'd1: begin
            mfl   <= reg_wdata[1:0];
            stuff <= reg_wdata[2];
          end
          2'd2: begin
            first_ptr <= reg_wdata[AW-1:0];
            cur_desc  <= reg_wdata[AW-1:0];
          end
          default: cur_desc <= reg_wdata[AW-1:0];
        endcase
      end
      if (abort_busy) begin
        if (st != S_IDLE) st <= S_IDLE;
        else begin
          abort_busy <= 1'b0;
          cur_desc   <= first_ptr;
        end
      end else begin
        case (st)
          S_IDLE: if (rx_on && rx_valid) begin
            st <= S_FETCH; fc <= '0; firstd <= 1'b1; flen <= '0; errd <= 1'b0;
          end
          S_FETCH: begin
            fc <= fc + 1'b1;
            if (fc < 3'd4) begin
              mem_rd   <= 1'b1;
              mem_addr <= cur_desc + AW'({fc[1:0], 2'b00});
            end
            case (fc)
              3'd2: begin own <= mem_rdata[31]; irqb <= mem_rdata[23]; end
              3'd3: dsize <= mem_rdata[31:16];
              3'd4: dbuf <= mem_rdata[AW-1:0];
              3'd5: begin
                dnext <= mem_rdata[AW-1:0];
                wbuf  <= '0;
                if (own) begin
                  st  <= S_DATA;
                  cnt <= (firstd && stuff) ? CW'(2) : '0;
                end else begin
                  st         <= S_DROP;
                  irq_nodesc <= 1'b1;
                end
              end
              default: ;
            endcase
          end
          S_DATA: if (acc) begin
            wbuf <= merged;
            cnt  <= cnt_n;
            flen <= flen_n;
            if ((rx_last && rx_err) || (flen_n > limit)) errd <= 1'b1;
            if (lane == 2'd3 || rx_last || buf_full) begin
              mem_wr    <= 1'b1;
              mem_addr  <= dbuf + AW'({cnt[CW-1:2], 2'b00});
              mem_wdata <= merged;
            end
            if (rx_last || buf_full) begin
              st    <= S_CNT;
              lastd <= rx_last;
            end
          end
          S_CNT: begin
            mem_wr    <= 1'b1;
            mem_addr  <= cur_desc + AW'(4);
            mem_wdata <= {dsize, cnt};
            st        <= S_STAT;
          end
          S_STAT: begin
            mem_wr    <= 1'b1;
            mem_addr  <= cur_desc;
            mem_wdata <= {1'b0, 7'd0, irqb, 5'd0, firstd, lastd, lastd & errd, 15'd0};
            cur_desc  <= dnext;
            irq_done  <= lastd & irqb;
            firstd    <= 1'b0;
            if (lastd) st <= S_IDLE;
            else begin
              st <= S_FETCH;
              fc <= '0;
            end
          end
          S_DROP: if (acc && rx_last) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_ring_dma_chk.sv
module rx_ring_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_ready,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [31:0] mem_wdata,
  input logic        irq_done,
  input logic        irq_nodesc,
  input logic        abort_busy
);
  a_r3_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r10_done_on_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> mem_wr && mem_wdata[16] && mem_wdata[23] && !mem_wdata[31]);

  a_r9_nodesc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    irq_nodesc |-> !mem_wr && !irq_done);

  a_r6_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_busy && $past(abort_busy)) |-> !rx_ready && !mem_wr);
endmodule

bind rx_ring_dma rx_ring_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .mem_rd(mem_rd),
  .mem_wr(mem_wr), .mem_wdata(mem_wdata), .irq_done(irq_done),
  .irq_nodesc(irq_nodesc), .abort_busy(abort_busy)
);

// File: tb/test_rx_ring_dma.sv
`timescale 1ns/1ps
module test_rx_ring_dma;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0; logic [1:0] reg_sel = '0; logic [31:0] reg_wdata = '0;
  logic rx_valid = 1'b0, rx_last = 1'b0, rx_err = 1'b0; logic [7:0] rx_data = '0;
  logic rx_ready, mem_rd, mem_wr, irq_done, irq_nodesc, rx_on, abort_busy;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, cur_desc;
  logic tb_we = 1'b0; logic [31:0] tb_a = '0, tb_d = '0;
  logic [31:0] mem [0:8191];

  int checks = 0, errors = 0;
  int n_done = 0, n_nod = 0, exp_done = 0, exp_nod = 0;
  int exp_a[$]; logic [31:0] exp_d[$];
  bit m_own[4]; bit m_irq[4]; int m_size[4];
  int m_cur = 0; bit m_stuff = 0; int m_lim = 1518;

  always #2 clk = ~clk;

  rx_ring_dma i_rx_ring_dma (.*);

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[14:2]] <= mem_wdata;
    else if (tb_we) mem[tb_a[14:2]] <= tb_d;
    if (mem_rd) mem_rdata <= mem[mem_addr[14:2]];
  end

  function automatic int daddr(int i); return 32'h100 + 16 * i; endfunction
  function automatic int baddr(int i); return 32'h1000 * (i + 1); endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (irq_done) n_done++;
    if (irq_nodesc) n_nod++;
    if (mem_wr) begin
      if (exp_a.size() == 0) chk(0, "R3", "unexpected write", mem_addr, 0);
      else begin
        int a; logic [31:0] d;
        a = exp_a.pop_front(); d = exp_d.pop_front();
        chk(mem_addr == a && mem_wdata == d, "R3", "write stream", {mem_addr, mem_wdata}, {a[31:0], d});
      end
    end
  end

  task automatic poke(int a, logic [31:0] d);
    @(negedge clk); tb_we = 1; tb_a = a; tb_d = d;
    @(negedge clk); tb_we = 0;
  endtask

  task automatic set_desc(int i, bit own, bit irq, int size);
    m_own[i] = own; m_irq[i] = irq; m_size[i] = size;
    poke(daddr(i), {own, 7'd0, irq, 23'd0});
    poke(daddr(i) + 4, {size[15:0], 16'd0});
    poke(daddr(i) + 8, baddr(i));
    poke(daddr(i) + 12, daddr((i + 1) % 4));
  endtask

  task automatic wreg(logic [1:0] s, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic model(int fr[$], bit err);
    int st[$]; int d, idx, n; bit first, last, bad;
    if (m_stuff) begin st.push_back(0); st.push_back(0); end
    foreach (fr[i]) st.push_back(fr[i]);
    bad = err || (fr.size() > m_lim);
    d = m_cur; idx = 0; first = 1;
    if (!m_own[d]) begin exp_nod++; return; end
    forever begin
      n = st.size() - idx;
      if (n > m_size[d]) n = m_size[d];
      for (int w = 0; w < (n + 3) / 4; w++) begin
        logic [31:0] v = 0;
        for (int b = 0; b < 4; b++)
          if (w * 4 + b < n) v[8*b +: 8] = st[idx + w * 4 + b];
        exp_a.push_back(baddr(d) + 4 * w); exp_d.push_back(v);
      end
      exp_a.push_back(daddr(d) + 4); exp_d.push_back({m_size[d][15:0], n[15:0]});
      last = (idx + n == st.size());
      exp_a.push_back(daddr(d));
      exp_d.push_back({8'd0, m_irq[d], 5'd0, first, last, last && bad, 15'd0});
      if (last && m_irq[d]) exp_done++;
      m_own[d] = 0; idx += n; first = 0; d = (d + 1) % 4;
      if (last) break;
    end
    m_cur = d;
  endtask

  task automatic send(string req, int len, bit err, int seed);
    int fr[$];
    for (int i = 0; i < len; i++) fr.push_back((seed + i * 7) & 8'hff);
    model(fr, err);
    @(negedge clk);
    for (int i = 0; i < len; i++) begin
      rx_valid = 1; rx_data = fr[i][7:0]; rx_last = (i == len - 1); rx_err = err && (i == len - 1);
      while (!rx_ready) @(negedge clk);
      @(negedge clk);
    end
    rx_valid = 0; rx_last = 0; rx_err = 0;
    repeat (12) @(negedge clk);
    chk(exp_a.size() == 0, req, "writes outstanding", exp_a.size(), 0);
    chk(n_done == exp_done, req, "irq_done count", n_done, exp_done);
    chk(n_nod == exp_nod, req, "irq_nodesc count", n_nod, exp_nod);
    chk(cur_desc == daddr(m_cur), req, "current pointer", cur_desc, daddr(m_cur));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!rx_ready && !mem_wr && !mem_rd, "R5", "reset outputs", {rx_ready, mem_wr, mem_rd}, 0);
    chk(cur_desc == 0 && !abort_busy && !rx_on, "R12", "reset registers", cur_desc, 0);

    for (int i = 0; i < 4; i++) set_desc(i, 1, 1, 64);
    wreg(2'd1, 32'h4); m_stuff = 1; m_lim = 1518;
    wreg(2'd2, 32'h100); m_cur = 0;
    chk(cur_desc == 32'h100, "R12", "first pointer loads current", cur_desc, 32'h100);
    wreg(2'd0, 32'h80);

    send("R2", 10, 0, 3);
    send("R4", 100, 0, 11);
    set_desc(3, 0, 1, 64);
    send("R9", 20, 0, 5);
    set_desc(3, 1, 0, 64);
    send("R8", 5, 1, 9);
    chk(cur_desc == 32'h100, "R1", "ring wrap", cur_desc, 32'h100);

    wreg(2'd1, 32'h0); m_stuff = 0; m_lim = 1518;
    set_desc(0, 1, 1, 2048); set_desc(1, 1, 1, 2048);
    send("R7", 1518, 0, 1);
    send("R7", 1519, 0, 2);
    wreg(2'd1, 32'h2); m_lim = 2048;
    set_desc(2, 1, 1, 2048); set_desc(3, 1, 1, 64);
    send("R7", 2000, 0, 4);
    send("R11", 7, 0, 6);

    wreg(2'd3, 32'h120);
    chk(cur_desc == 32'h120, "R12", "current pointer write", cur_desc, 32'h120);
    wreg(2'd0, 32'h8080);
    chk(abort_busy == 1, "R6", "abort pending", abort_busy, 1);
    @(negedge clk);
    chk(abort_busy == 0, "R6", "abort self-clear", abort_busy, 0);
    chk(cur_desc == 32'h100, "R6", "pointer reload", cur_desc, 32'h100);
    m_cur = 0;

    wreg(2'd0, 32'h0);
    chk(rx_on == 0, "R5", "enable cleared", rx_on, 0);
    @(negedge clk); rx_valid = 1; rx_data = 8'h55; rx_last = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(!rx_ready && !mem_rd, "R5", "disabled idle", {rx_ready, mem_rd}, 0);
    end
    rx_valid = 0; rx_last = 0;
    wreg(2'd0, 32'h80);
    wreg(2'd1, 32'h4); m_stuff = 1; m_lim = 1518;
    set_desc(0, 1, 1, 64);
    send("R10", 3, 0, 8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule